// File: doc/BRIEF.md
# DMA Source Address Stepper

This block produces the read addresses for one DMA channel. It holds a stored source address. For each transfer unit it issues one or more bus read cycles. When the unit ends, it writes the next stored address. A unit is a byte, a word or a longword. When a word or longword unit starts on an address that is not aligned to its size, the unit is split into smaller aligned bus cycles. Each of those cycles carries its own intermediate address.

A controller first loads a start address. It then requests units through a valid/ready handshake (`start_valid`/`start_ready`). The address mode, unit size and signed offset are sampled when a request is accepted. Read cycles go to a bus-cycle engine through a second valid/ready pair (`bus_valid`/`bus_ready`). When the engine holds `bus_ready` low, that is back-pressure: the offered address and size stay unchanged until a cycle where both valid and ready are high. A new request is accepted only while no unit is in flight. While the block is idle, `bus_addr` shows the stored address.

Top module: `dma_src_addr_unit`

## Requirements
- R1: After reset `bus_valid` is 0, `start_ready` is 1 and the stored address shown on `bus_addr` is 0.
- R2: When `load_en` is high at a clock edge, the stored address becomes `load_addr` and any unit in flight is abandoned. After that edge `bus_valid` is 0. Load takes priority over every other input.
- R3: `start_ready` equals the inverse of `bus_valid`. A request accepted at an edge makes `bus_valid` high after that edge, and the first cycle carries the stored address.
- R4: While `bus_valid` is high and `bus_ready` is low, `bus_addr` and `bus_size` hold their values.
- R5: `data_size` codes are 00 for byte (1 byte), 01 for word (2 bytes) and 10 for longword (4 bytes). Code 11 behaves as byte. `bus_size` uses the same codes 00, 01 and 10.
- R6: Split patterns, where a word needs bit 0 clear and a longword needs bits 1:0 clear. An odd word becomes byte then byte. A longword with low bits 01 or 11 becomes byte, word, byte. A longword with low bits 10 becomes word then word. An aligned unit is a single cycle.
- R7: Within a split unit, each cycle's address is the previous cycle's address plus that previous cycle's byte count.
- R8: `unit_done` is high in exactly the clock where the last cycle of a unit is handshaked. The stored address is written at that same edge, and `bus_valid` is 0 after it.
- R9: Mode 00 (fixed) leaves the stored address at the unit's start address, also after a split unit.
- R10: Mode 01 adds `offset` to the unit's start address with 32-bit wraparound. A negative offset is given in two's complement form.
- R11: Mode 10 adds, and mode 11 subtracts, the unit's byte count to or from the unit's start address, with 32-bit wraparound. The last intermediate address is never used for this.
- R12: `addr_mode`, `data_size` and `offset` are sampled at request acceptance. Changes to them while a unit is in flight have no effect on that unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write `load_addr` as the stored address and abort any unit |
| load_addr | input | 32 | New start address |
| start_valid | input | 1 | Request one transfer unit |
| start_ready | output | 1 | High when a request can be accepted |
| addr_mode | input | 2 | 00 fixed, 01 offset, 10 increment, 11 decrement |
| data_size | input | 2 | 00 byte, 01 word, 10 longword, 11 treated as byte |
| offset | input | 32 | Two's-complement offset for mode 01 |
| bus_valid | output | 1 | A read cycle is offered |
| bus_ready | input | 1 | Bus engine acknowledges the offered cycle |
| bus_addr | output | 32 | Cycle address while valid, stored address while idle |
| bus_size | output | 2 | Cycle size: 00 byte, 01 word, 10 longword |
| unit_done | output | 1 | Last cycle of the unit is handshaked in this clock |

## Verification
`bus_valid` rises one edge after a request is accepted. Each following cycle address appears one edge after the previous handshake. The stored address is visible on `bus_addr` one edge after the handshake that raises `unit_done`. `unit_done` itself is combinational, so it is due in the same clock as the last handshake. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge. It compares every output 5 ns before the next rising edge. At that point, both registered results of the last edge and combinational results of the current inputs have settled.

// File: rtl/dsau_pkg.sv
package dsau_pkg;
  typedef enum logic [1:0] {
    AM_FIXED  = 2'b00,
    AM_OFFSET = 2'b01,
    AM_INC    = 2'b10,
    AM_DEC    = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } asize_e;

  // most bus cycles a single unit can need
  localparam int unsigned SPLIT_MAX = 3;
  localparam int unsigned IDX_W     = $clog2(SPLIT_MAX);

  function automatic asize_e norm_size(input logic [1:0] code);
    return (code == SZ_RSVD) ? SZ_BYTE : asize_e'(code);
  endfunction

  function automatic logic [2:0] size_bytes(input asize_e sz);
    case (sz)
      SZ_WORD: return 3'd2;
      SZ_LONG: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dsau_split.sv
module dsau_split
  import dsau_pkg::*;
(
  input  asize_e           unit_size,
  input  logic [1:0]       start_lo,
  input  logic [IDX_W-1:0] idx,
  output asize_e           cyc_size,
  output logic             cyc_last
);
  always_comb begin
    cyc_size = SZ_BYTE;
    cyc_last = 1'b1;
    case (unit_size)
      SZ_WORD: begin
        if (start_lo[0]) begin
          cyc_size = SZ_BYTE;
          cyc_last = (idx == IDX_W'(1));
        end else begin
          cyc_size = SZ_WORD;
        end
      end
      SZ_LONG: begin
        case (start_lo)
          2'b00: cyc_size = SZ_LONG;
          2'b10: begin
            cyc_size = SZ_WORD;
            cyc_last = (idx == IDX_W'(1));
          end
          default: begin
            cyc_size = (idx == IDX_W'(1)) ? SZ_WORD : SZ_BYTE;
            cyc_last = (idx == IDX_W'(2));
          end
        endcase
      end
      default: begin
        cyc_size = SZ_BYTE;
        cyc_last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/dsau_next.sv
module dsau_next
  import dsau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  amode_e            mode,
  input  asize_e            unit_size,
  input  logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int unsigned PAD_W = ADDR_W - 3;
  logic [ADDR_W-1:0] step;

  assign step = {{PAD_W{1'b0}}, size_bytes(unit_size)};

  always_comb begin
    case (mode)
      AM_OFFSET: next_addr = start_addr + offset;
      AM_INC:    next_addr = start_addr + step;
      AM_DEC:    next_addr = start_addr - step;
      default:   next_addr = start_addr;
    endcase
  end
endmodule

// File: rtl/dsau_seq.sv
module dsau_seq
  import dsau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              start_fire,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        mode_in,
  input  logic [1:0]        size_in,
  input  logic [ADDR_W-1:0] offset_in,
  input  logic              bus_ready,
  input  asize_e            cyc_size,
  input  logic              cyc_last,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [IDX_W-1:0]  idx,
  output amode_e            mode_q,
  output asize_e            size_q,
  output logic [ADDR_W-1:0] offset_q,
  output logic              commit
);
  localparam int unsigned PAD_W = ADDR_W - 3;
  logic cyc_fire;

  assign cyc_fire = busy && bus_ready;
  assign commit   = cyc_fire && cyc_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      idx      <= '0;
      mode_q   <= AM_FIXED;
      size_q   <= SZ_BYTE;
      offset_q <= '0;
    end else if (load_en) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start_fire) begin
      busy     <= 1'b1;
      cur_addr <= start_addr;
      idx      <= '0;
      mode_q   <= amode_e'(mode_in);
      size_q   <= norm_size(size_in);
      offset_q <= offset_in;
    end else if (cyc_fire) begin
      if (cyc_last) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        cur_addr <= cur_addr + {{PAD_W{1'b0}}, size_bytes(cyc_size)};
        idx      <= idx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma_src_addr_unit.sv
module dma_src_addr_unit
  import dsau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [1:0]        addr_mode,
  input  logic [1:0]        data_size,
  input  logic [ADDR_W-1:0] offset,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic              unit_done
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] offset_q;
  logic [IDX_W-1:0]  idx;
  logic              busy;
  logic              commit;
  logic              cyc_last;
  amode_e            mode_q;
  asize_e            size_q;
  asize_e            cyc_size;

  assign start_ready = !busy;
  assign bus_valid   = busy;
  assign bus_addr    = busy ? cur_addr : base_q;
  assign bus_size    = cyc_size;
  assign unit_done   = commit;

  dsau_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .start_fire (start_valid && !busy),
    .start_addr (base_q),
    .mode_in    (addr_mode),
    .size_in    (data_size),
    .offset_in  (offset),
    .bus_ready  (bus_ready),
    .cyc_size   (cyc_size),
    .cyc_last   (cyc_last),
    .busy       (busy),
    .cur_addr   (cur_addr),
    .idx        (idx),
    .mode_q     (mode_q),
    .size_q     (size_q),
    .offset_q   (offset_q),
    .commit     (commit)
  );

  dsau_split u_split (
    .unit_size (size_q),
    .start_lo  (base_q[1:0]),
    .idx       (idx),
    .cyc_size  (cyc_size),
    .cyc_last  (cyc_last)
  );

  dsau_next #(.ADDR_W(ADDR_W)) u_next (
    .start_addr (base_q),
    .mode       (mode_q),
    .unit_size  (size_q),
    .offset     (offset_q),
    .next_addr  (next_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (load_en) base_q <= load_addr;
    else if (commit)  base_q <= next_addr;
  end
endmodule

// File: rtl/dsau_checker.sv
module dsau_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_addr,
  input logic              start_valid,
  input logic              start_ready,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              unit_done
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready && !load_en |=> bus_valid && $stable(bus_addr) && $stable(bus_size));

  assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size == 2'b00) || (bus_size == 2'b01 && !bus_addr[0]) ||
                  (bus_size == 2'b10 && bus_addr[1:0] == 2'b00));

  assert_done_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> bus_valid && bus_ready);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> !bus_valid && start_ready);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !bus_valid && bus_addr == $past(load_addr));

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && !load_en |=> bus_valid && bus_addr == $past(bus_addr));
endmodule

bind dma_src_addr_unit dsau_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_en     (load_en),
  .load_addr   (load_addr),
  .start_valid (start_valid),
  .start_ready (start_ready),
  .bus_valid   (bus_valid),
  .bus_ready   (bus_ready),
  .bus_addr    (bus_addr),
  .bus_size    (bus_size),
  .unit_done   (unit_done)
);

// File: tb/dma_src_addr_unit_test.sv
module dma_src_addr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_addr = '0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [1:0]  addr_mode = '0;
  logic [1:0]  data_size = '0;
  logic [31:0] offset = '0;
  logic        bus_valid;
  logic        bus_ready = 1'b0;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        unit_done;

  always #10 clk = ~clk;

  dma_src_addr_unit uut (.*);

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_base = '0;
  bit          m_busy = 0;
  logic [1:0]  m_mode;
  int          m_bytes;
  logic [31:0] m_off;
  logic [31:0] q_addr[$];
  logic [1:0]  q_size[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = '0; m_busy = 0; q_addr.delete(); q_size.delete();
    end else if (load_en) begin
      m_base = load_addr; m_busy = 0; q_addr.delete(); q_size.delete();
    end else if (m_busy) begin
      if (bus_ready) begin
        void'(q_addr.pop_front());
        void'(q_size.pop_front());
        if (q_addr.size() == 0) begin
          m_busy = 0;
          case (m_mode)
            2'b01: m_base = m_base + m_off;
            2'b10: m_base = m_base + 32'(m_bytes);
            2'b11: m_base = m_base - 32'(m_bytes);
            default: ;
          endcase
        end
      end
    end else if (start_valid) begin
      logic [31:0] a;
      int rem;
      m_busy  = 1;
      m_mode  = addr_mode;
      m_off   = offset;
      m_bytes = (data_size == 2'b01) ? 2 : (data_size == 2'b10) ? 4 : 1;
      a = m_base;
      rem = m_bytes;
      while (rem > 0) begin
        int c;
        if (a[1:0] == 2'b00 && rem >= 4) c = 4;
        else if (!a[0] && rem >= 2) c = 2;
        else c = 1;
        q_addr.push_back(a);
        q_size.push_back(c == 4 ? 2'b10 : c == 2 ? 2'b01 : 2'b00);
        a = a + 32'(c);
        rem -= c;
      end
    end
  end

  // per-clock comparison, 5 ns before the rising edge
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      check(start_ready == !m_busy, "R3 start_ready", 32'(start_ready), 32'(!m_busy));
      check(bus_valid == m_busy, "R3 bus_valid", 32'(bus_valid), 32'(m_busy));
      if (m_busy) begin
        check(bus_addr == q_addr[0], "R7 cycle address", bus_addr, q_addr[0]);
        check(bus_size == q_size[0], "R6 cycle size", 32'(bus_size), 32'(q_size[0]));
      end else begin
        check(bus_addr == m_base, "R11 stored address", bus_addr, m_base);
      end
      check(unit_done == (m_busy && bus_ready && q_addr.size() == 1), "R8 unit_done",
            32'(unit_done), 32'(m_busy && bus_ready && q_addr.size() == 1));
    end
  end

  task automatic do_load(input logic [31:0] a);
    @(negedge clk);
    load_en = 1; load_addr = a;
    @(negedge clk);
    load_en = 0;
  endtask

  // one unit; inputs are scrambled after acceptance (R12)
  task automatic run_unit(input logic [1:0] mode, input logic [1:0] size, input logic [31:0] off,
                          input int hold);
    @(negedge clk);
    start_valid = 1; addr_mode = mode; data_size = size; offset = off; bus_ready = 0;
    @(negedge clk);
    start_valid = 0; addr_mode = ~mode; data_size = ~size; offset = ~off;
    repeat (hold) @(negedge clk);
    forever begin
      bus_ready = ($urandom_range(3) != 0);
      @(negedge clk);
      if (!bus_valid) break;
    end
    bus_ready = 0;
  endtask

  task automatic expect_addr(input logic [31:0] e, input string req);
    #6;
    check(bus_addr == e && !bus_valid, req, bus_addr, e);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    check(bus_valid == 0 && start_ready == 1, "R1 reset handshake", {bus_valid, start_ready}, 32'b01);
    check(bus_addr == 0, "R1 reset address", bus_addr, 0);
    @(negedge clk);
    rst_n = 1;

    do_load(32'h0000_1000);
    run_unit(2'b10, 2'b10, 0, 0);
    expect_addr(32'h0000_1004, "R11 inc longword");
    do_load(32'h0000_1003);
    run_unit(2'b10, 2'b10, 0, 3);
    expect_addr(32'h0000_1007, "R11 inc split longword from start");
    do_load(32'h0000_2001);
    run_unit(2'b11, 2'b01, 0, 0);
    expect_addr(32'h0000_1FFF, "R11 dec odd word");
    do_load(32'h0000_3001);
    run_unit(2'b00, 2'b10, 0, 2);
    expect_addr(32'h0000_3001, "R9 fixed after split");
    do_load(32'h0000_3002);
    run_unit(2'b00, 2'b10, 0, 0);
    expect_addr(32'h0000_3002, "R9 fixed after word-word split");
    do_load(32'h0002_0000);
    run_unit(2'b01, 2'b01, 32'hFFFE_0001, 0);
    expect_addr(32'h0000_0001, "R10 negative offset");
    do_load(32'hFFFF_FFF0);
    run_unit(2'b01, 2'b00, 32'h0000_0020, 0);
    expect_addr(32'h0000_0010, "R10 offset wrap");
    do_load(32'h0000_0000);
    run_unit(2'b11, 2'b10, 0, 0);
    expect_addr(32'hFFFF_FFFC, "R11 dec wrap");
    do_load(32'h0000_0010);
    run_unit(2'b10, 2'b11, 0, 0);
    expect_addr(32'h0000_0011, "R5 reserved size as byte");

    // R2: load during a split unit
    do_load(32'h0000_4001);
    @(negedge clk);
    start_valid = 1; addr_mode = 2'b10; data_size = 2'b10; bus_ready = 0;
    @(negedge clk);
    start_valid = 0; bus_ready = 1;
    @(negedge clk);
    bus_ready = 0; load_en = 1; load_addr = 32'h0000_5000;
    @(negedge clk);
    load_en = 0;
    #6;
    check(!bus_valid && bus_addr == 32'h0000_5000, "R2 load aborts split", bus_addr, 32'h0000_5000);

    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(7) == 0) do_load($urandom);
      run_unit(2'($urandom_range(3)), 2'($urandom_range(3)), $urandom, $urandom_range(2));
    end

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule